// File: doc/BRIEF.md
# USB Endpoint-Zero Control Sequencer

This block follows a control transfer on endpoint zero through its setup, data and status stages when firmware, not hardware, interprets the request. The serial interface engine feeds it decoded packet events: a SETUP, IN or OUT token, a data-phase-complete strobe with a zero-length indication, and the first byte of a received packet. For each completed transaction the block chooses the handshake (ACK or STALL). It raises one interrupt pulse for setup, receive or transmit, and it keeps two sticky status flags, one for ACK and one for STALL, which firmware clears.

Firmware uses the setup interrupt to read and decode the command. If the command cannot be served, firmware pulses the stall command. Every later data-stage and status-stage transaction of that transfer is then answered with STALL. Each such transaction still raises its receive or transmit interrupt, so firmware sees every transaction.

Top module: `ep0_ctrl_seq`

## Requirements
- R1: After reset, `stage` is 0 (idle) and every handshake, interrupt and flag output is 0.
- R2: A SETUP token followed by `pktDone` gives, on the next cycle, an ACK handshake (`hsValid`=1, `hsStall`=0) and a one-cycle `setupIrq`. `stage` becomes 2 (data) and `readXfer` takes bit 7 of `firstByte`. `ackFlag` and `stallFlag` keep their values.
- R3: In a write (`readXfer`=0) data stage, an OUT token then `pktDone` gives an ACK, a `rxIrq` pulse and sets `ackFlag`. `stage` stays 2.
- R4: In a read (`readXfer`=1) data stage, an IN token then `pktDone` gives an ACK, a `txIrq` pulse and sets `ackFlag`. `stage` stays 2.
- R5: In the data stage, a token whose direction is opposite to the transfer (IN for a write, OUT for a read) moves `stage` to 3 (status). This also holds with no data transaction, so a write may go straight from setup to status.
- R6: A status transaction that completes with `zeroLen`=1 and no stall pending gives an ACK and sets `ackFlag`. It raises `txIrq` for an IN status or `rxIrq` for an OUT status, and `stage` returns to 0.
- R7: A status transaction that completes with `zeroLen`=0 is answered with STALL and sets `stallFlag`. It still raises its interrupt, and `stage` returns to 0.
- R8: After `stallCmd` in the data or status stage, every later data-stage and status-stage completion of that transfer gives `hsStall`=1 and sets `stallFlag`, not `ackFlag`. It still raises the matching `rxIrq` or `txIrq`.
- R9: `stallCmd` given while the command packet is still awaited (`stage`=1) has no effect, and the later data transactions are ACKed.
- R10: A SETUP token in any stage puts `stage` at 1 on the next cycle and drops a pending stall. No handshake is produced for the open transaction.
- R11: `setupIrq`, `rxIrq`, `txIrq` and `hsValid` are one-cycle pulses. At most one interrupt fires per cycle, always together with `hsValid`.
- R12: `ackFlag` and `stallFlag` hold until `clrAck` or `clrStall` is pulsed. A set in the same cycle as a clear wins.
- R13: `pktDone` with no open token, and IN or OUT tokens while idle, produce no handshake, no interrupt and no stage change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setupTok | input | 1 | SETUP token decoded (pulse) |
| inTok | input | 1 | IN token to endpoint zero (pulse) |
| outTok | input | 1 | OUT token to endpoint zero (pulse) |
| pktDone | input | 1 | Data phase of the open transaction finished (pulse) |
| zeroLen | input | 1 | The finished data packet had no payload |
| firstByte | input | BYTE_W | First byte of the received data packet |
| stallCmd | input | 1 | Firmware request to stall the rest of the transfer (pulse) |
| clrAck | input | 1 | Write-one-to-clear strobe for `ackFlag` |
| clrStall | input | 1 | Write-one-to-clear strobe for `stallFlag` |
| hsValid | output | 1 | Handshake decision valid (pulse) |
| hsStall | output | 1 | Handshake is STALL (1) or ACK (0) |
| setupIrq | output | 1 | Setup stage done interrupt (pulse) |
| rxIrq | output | 1 | Receive interrupt (pulse) |
| txIrq | output | 1 | Transmit interrupt (pulse) |
| ackFlag | output | 1 | Sticky ACK status |
| stallFlag | output | 1 | Sticky STALL status |
| stage | output | 2 | 0 idle, 1 setup, 2 data, 3 status |
| readXfer | output | 1 | Current transfer is device-to-host |

## Verification
The assertions assume that the engine asserts at most one of `setupTok`, `inTok` and `outTok` per cycle. They also assume that `pktDone` arrives only after the token of its transaction. Under these conditions the handshake and interrupt pulses stay paired and the flags can only rise together with a handshake of their own kind. The bench drives each event as a single-cycle pulse on the falling edge, one event per cycle, and in protocol order. The only exceptions are deliberate orphan `pktDone` pulses and one clear strobe placed on purpose in the same cycle as a flag set.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_DATA   = 2'd2,
    ST_STATUS = 2'd3
  } stage_e;

  // Strobes from the control FSM to the datapath registers.
  typedef struct packed {
    logic hsAck;
    logic hsStall;
    logic irqSetup;
    logic irqRx;
    logic irqTx;
    logic latchDir;
    logic armStall;
    logic dropStall;
  } seqStrobe_t;

endpackage

// File: rtl/ep0_seq_ctrl.sv
module ep0_seq_ctrl
  import ep0_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       setupTok,
  input  logic       inTok,
  input  logic       outTok,
  input  logic       pktDone,
  input  logic       zeroLen,
  input  logic       stallCmd,
  input  logic       readXfer,
  input  logic       stallPend,
  output seqStrobe_t str,
  output stage_e     stage
);

  stage_e state, nState;
  logic   tokOpen, nOpen;
  logic   tokIsIn, nIsIn;
  logic   doneNow, stallIt;
  logic   tokAny, tokOpposite;

  assign tokAny      = inTok | outTok;
  assign tokOpposite = tokAny && (inTok != readXfer);
  assign stage       = state;

  always_comb begin
    str     = '0;
    nState  = state;
    nOpen   = tokOpen;
    nIsIn   = tokIsIn;
    doneNow = 1'b0;
    stallIt = 1'b0;
    if (setupTok) begin
      nState        = ST_SETUP;
      nOpen         = 1'b0;
      str.dropStall = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_SETUP: begin
          if (pktDone) begin
            str.hsAck    = 1'b1;
            str.irqSetup = 1'b1;
            str.latchDir = 1'b1;
            nState       = ST_DATA;
          end
        end
        ST_DATA: begin
          if (tokAny) begin
            nOpen = 1'b1;
            nIsIn = inTok;
            if (tokOpposite) nState = ST_STATUS;
          end else if (pktDone && tokOpen) begin
            doneNow = 1'b1;
            stallIt = stallPend;
          end
        end
        ST_STATUS: begin
          if (tokOpposite) begin
            nOpen = 1'b1;
            nIsIn = inTok;
          end else if (pktDone && tokOpen) begin
            doneNow = 1'b1;
            stallIt = stallPend | ~zeroLen;
            nState  = ST_IDLE;
          end
        end
      endcase
      if (stallCmd && (state == ST_DATA || state == ST_STATUS))
        str.armStall = 1'b1;
    end
    if (doneNow) begin
      nOpen       = 1'b0;
      str.hsStall = stallIt;
      str.hsAck   = ~stallIt;
      str.irqTx   = tokIsIn;
      str.irqRx   = ~tokIsIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tokOpen <= 1'b0;
      tokIsIn <= 1'b0;
    end else begin
      state   <= nState;
      tokOpen <= nOpen;
      tokIsIn <= nIsIn;
    end
  end

endmodule

// File: rtl/ep0_seq_dp.sv
module ep0_seq_dp
  import ep0_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t str,
  input  logic       dirBit,
  input  logic       clrAck,
  input  logic       clrStall,
  output logic       hsValid,
  output logic       hsStall,
  output logic       setupIrq,
  output logic       rxIrq,
  output logic       txIrq,
  output logic       ackFlag,
  output logic       stallFlag,
  output logic       readXfer,
  output logic       stallPend
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsValid   <= 1'b0;
      hsStall   <= 1'b0;
      setupIrq  <= 1'b0;
      rxIrq     <= 1'b0;
      txIrq     <= 1'b0;
      ackFlag   <= 1'b0;
      stallFlag <= 1'b0;
      readXfer  <= 1'b0;
      stallPend <= 1'b0;
    end else begin
      hsValid  <= str.hsAck | str.hsStall;
      hsStall  <= str.hsStall;
      setupIrq <= str.irqSetup;
      rxIrq    <= str.irqRx;
      txIrq    <= str.irqTx;
      // Flags: a set in the same cycle as a clear wins.
      if (str.hsAck && !str.irqSetup) ackFlag <= 1'b1;
      else if (clrAck)                ackFlag <= 1'b0;
      if (str.hsStall)                stallFlag <= 1'b1;
      else if (clrStall)              stallFlag <= 1'b0;
      if (str.latchDir) readXfer <= dirBit;
      if (str.dropStall)     stallPend <= 1'b0;
      else if (str.armStall) stallPend <= 1'b1;
    end
  end

endmodule

// File: rtl/ep0_ctrl_seq.sv
module ep0_ctrl_seq
  import ep0_seq_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int DIR_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setupTok,
  input  logic              inTok,
  input  logic              outTok,
  input  logic              pktDone,
  input  logic              zeroLen,
  input  logic [BYTE_W-1:0] firstByte,
  input  logic              stallCmd,
  input  logic              clrAck,
  input  logic              clrStall,
  output logic              hsValid,
  output logic              hsStall,
  output logic              setupIrq,
  output logic              rxIrq,
  output logic              txIrq,
  output logic              ackFlag,
  output logic              stallFlag,
  output logic [1:0]        stage,
  output logic              readXfer
);

  seqStrobe_t str;
  stage_e     stageQ;
  logic       stallPend;
  logic       unusedCmdBits;

  assign unusedCmdBits = ^firstByte;
  assign stage         = stageQ;

  ep0_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .setupTok(setupTok), .inTok(inTok), .outTok(outTok),
    .pktDone(pktDone), .zeroLen(zeroLen), .stallCmd(stallCmd),
    .readXfer(readXfer), .stallPend(stallPend),
    .str(str), .stage(stageQ)
  );

  ep0_seq_dp u_dp (
    .clk(clk), .rstN(rstN), .str(str),
    .dirBit(firstByte[DIR_BIT]),
    .clrAck(clrAck), .clrStall(clrStall),
    .hsValid(hsValid), .hsStall(hsStall),
    .setupIrq(setupIrq), .rxIrq(rxIrq), .txIrq(txIrq),
    .ackFlag(ackFlag), .stallFlag(stallFlag),
    .readXfer(readXfer), .stallPend(stallPend)
  );

endmodule

// File: rtl/ep0_ctrl_seq_chk.sv
module ep0_ctrl_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       setupTok,
  input logic       hsValid,
  input logic       hsStall,
  input logic       setupIrq,
  input logic       rxIrq,
  input logic       txIrq,
  input logic       ackFlag,
  input logic       stallFlag,
  input logic [1:0] stage
);

  a_r11_one_irq: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({setupIrq, rxIrq, txIrq}));

  a_r11_irq_with_hs: assert property (@(posedge clk) disable iff (!rstN)
    (setupIrq | rxIrq | txIrq) == hsValid);

  a_r11_stall_needs_hs: assert property (@(posedge clk) disable iff (!rstN)
    hsStall |-> hsValid);

  a_r2_setup_is_ack: assert property (@(posedge clk) disable iff (!rstN)
    setupIrq |-> !hsStall);

  a_r12_ack_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackFlag) |-> (hsValid && !hsStall && !setupIrq));

  a_r12_stall_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stallFlag) |-> (hsValid && hsStall));

  a_r10_setup_restart: assert property (@(posedge clk) disable iff (!rstN)
    setupTok |=> (stage == 2'd1 && !hsValid));

  a_r6_status_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (hsValid && $past(stage) == 2'd3) |-> stage == 2'd0);

  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (stage == 2'd0 && !setupTok) |=> !hsValid);

endmodule

bind ep0_ctrl_seq ep0_ctrl_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .setupTok(setupTok),
  .hsValid(hsValid), .hsStall(hsStall),
  .setupIrq(setupIrq), .rxIrq(rxIrq), .txIrq(txIrq),
  .ackFlag(ackFlag), .stallFlag(stallFlag), .stage(stage)
);

// File: tb/tb_ep0_ctrl_seq.sv
module tb_ep0_ctrl_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setupTok = 0, inTok = 0, outTok = 0, pktDone = 0, zeroLen = 0;
  logic [7:0] firstByte = '0;
  logic stallCmd = 0, clrAck = 0, clrStall = 0;
  logic hsValid, hsStall, setupIrq, rxIrq, txIrq, ackFlag, stallFlag, readXfer;
  logic [1:0] stage;
  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep0_ctrl_seq dut (
    .clk(clk), .rstN(rstN), .setupTok(setupTok), .inTok(inTok), .outTok(outTok),
    .pktDone(pktDone), .zeroLen(zeroLen), .firstByte(firstByte),
    .stallCmd(stallCmd), .clrAck(clrAck), .clrStall(clrStall),
    .hsValid(hsValid), .hsStall(hsStall), .setupIrq(setupIrq),
    .rxIrq(rxIrq), .txIrq(txIrq), .ackFlag(ackFlag), .stallFlag(stallFlag),
    .stage(stage), .readXfer(readXfer)
  );

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic endCycle();
    @(negedge clk);
    setupTok = 0; inTok = 0; outTok = 0; pktDone = 0; zeroLen = 0;
    stallCmd = 0; clrAck = 0; clrStall = 0;
  endtask

  task automatic tokSetup(); setupTok = 1; endCycle(); endtask
  task automatic tokIn();    inTok = 1;    endCycle(); endtask
  task automatic tokOut();   outTok = 1;   endCycle(); endtask
  task automatic stallC();   stallCmd = 1; endCycle(); endtask
  task automatic doClrAck(); clrAck = 1;   endCycle(); endtask
  task automatic doClrStall(); clrStall = 1; endCycle(); endtask
  task automatic pkt(logic zl, logic [7:0] b);
    pktDone = 1; zeroLen = zl; firstByte = b; endCycle();
  endtask

  task automatic hsCheck(string req, int stl, int sIrq, int rIrq, int tIrq);
    chk(req, "hsValid", hsValid, 1);
    chk(req, "hsStall", hsStall, stl);
    chk(req, "setupIrq", setupIrq, sIrq);
    chk(req, "rxIrq", rxIrq, rIrq);
    chk(req, "txIrq", txIrq, tIrq);
  endtask

  task automatic setupStage(logic [7:0] b);
    tokSetup();
    chk("R10", "stage after SETUP", stage, 1);
    pkt(1'b0, b);
    hsCheck("R2", 0, 1, 0, 0);
    chk("R2", "stage", stage, 2);
    chk("R2", "readXfer", readXfer, b[7]);
  endtask

  task automatic testReset();
    chk("R1", "stage", stage, 0);
    chk("R1", "hsValid", hsValid, 0);
    chk("R1", "irqs", {setupIrq, rxIrq, txIrq}, 0);
    chk("R1", "flags", {ackFlag, stallFlag}, 0);
  endtask

  task automatic testWrite();
    setupStage(8'h00);
    chk("R2", "ackFlag untouched", ackFlag, 0);
    for (int k = 0; k < 2; k++) begin
      tokOut();
      chk("R3", "stage after OUT", stage, 2);
      chk("R13", "no hs on token", hsValid, 0);
      pkt(1'b0, 8'h55);
      hsCheck("R3", 0, 0, 1, 0);
      chk("R3", "ackFlag", ackFlag, 1);
      chk("R3", "stage", stage, 2);
      endCycle();
      chk("R11", "rxIrq pulse ends", rxIrq, 0);
      chk("R11", "hsValid pulse ends", hsValid, 0);
      chk("R12", "ackFlag sticky", ackFlag, 1);
    end
    tokIn();
    chk("R5", "stage status", stage, 3);
    pkt(1'b1, 8'h00);
    hsCheck("R6", 0, 0, 0, 1);
    chk("R6", "stage idle", stage, 0);
  endtask

  task automatic testRead();
    setupStage(8'h80);
    chk("R2", "ackFlag kept set", ackFlag, 1);
    doClrAck();
    chk("R12", "ackFlag cleared", ackFlag, 0);
    tokIn();
    pkt(1'b0, 8'h00);
    hsCheck("R4", 0, 0, 0, 1);
    chk("R4", "ackFlag", ackFlag, 1);
    chk("R4", "stage", stage, 2);
    tokOut();
    chk("R5", "stage status", stage, 3);
    pkt(1'b1, 8'h00);
    hsCheck("R6", 0, 0, 1, 0);
    chk("R6", "stage idle", stage, 0);
  endtask

  task automatic testNoData();
    doClrAck();
    setupStage(8'h00);
    tokIn();
    chk("R5", "direct to status", stage, 3);
    pkt(1'b1, 8'h00);
    hsCheck("R6", 0, 0, 0, 1);
    chk("R6", "ackFlag", ackFlag, 1);
    chk("R6", "stage idle", stage, 0);
  endtask

  task automatic testStall();
    doClrAck();
    setupStage(8'h00);
    stallC();
    tokOut();
    pkt(1'b0, 8'h00);
    hsCheck("R8", 1, 0, 1, 0);
    chk("R8", "stallFlag", stallFlag, 1);
    chk("R8", "ackFlag not set", ackFlag, 0);
    tokIn();
    pkt(1'b1, 8'h00);
    hsCheck("R8", 1, 0, 0, 1);
    chk("R8", "ackFlag status", ackFlag, 0);
    chk("R8", "stage idle", stage, 0);
  endtask

  task automatic testStallInSetup();
    doClrStall();
    chk("R12", "stallFlag cleared", stallFlag, 0);
    tokSetup();
    stallC();
    pkt(1'b0, 8'h00);
    hsCheck("R9", 0, 1, 0, 0);
    tokOut();
    pkt(1'b0, 8'h00);
    hsCheck("R9", 0, 0, 1, 0);
    chk("R9", "stallFlag", stallFlag, 0);
    tokIn();
    pkt(1'b1, 8'h00);
    chk("R9", "status ack", hsStall, 0);
  endtask

  task automatic testRestart();
    setupStage(8'h00);
    stallC();
    tokOut();
    tokSetup();
    chk("R10", "stage setup", stage, 1);
    chk("R10", "no handshake", hsValid, 0);
    pkt(1'b0, 8'h80);
    hsCheck("R10", 0, 1, 0, 0);
    chk("R10", "new direction", readXfer, 1);
    tokIn();
    pkt(1'b0, 8'h00);
    hsCheck("R10", 0, 0, 0, 1);
    tokOut();
    pkt(1'b1, 8'h00);
    chk("R10", "stage idle", stage, 0);
  endtask

  task automatic testBadStatus();
    doClrStall();
    setupStage(8'h80);
    tokOut();
    chk("R7", "stage status", stage, 3);
    pkt(1'b0, 8'h00);
    hsCheck("R7", 1, 0, 1, 0);
    chk("R7", "stallFlag", stallFlag, 1);
    chk("R7", "stage idle", stage, 0);
  endtask

  task automatic testFlags();
    doClrAck();
    setupStage(8'h00);
    tokOut();
    pktDone = 1; zeroLen = 0; clrAck = 1; endCycle();
    chk("R12", "set beats clear", ackFlag, 1);
    repeat (3) endCycle();
    chk("R12", "ackFlag holds", ackFlag, 1);
    chk("R12", "stallFlag holds", stallFlag, 1);
    doClrAck();
    chk("R12", "ackFlag w1c", ackFlag, 0);
    doClrStall();
    chk("R12", "stallFlag w1c", stallFlag, 0);
    tokIn();
    pkt(1'b1, 8'h00);
    chk("R12", "stage idle", stage, 0);
  endtask

  task automatic testOrphans();
    tokIn();
    pkt(1'b0, 8'h00);
    chk("R13", "idle hsValid", hsValid, 0);
    chk("R13", "idle irqs", {setupIrq, rxIrq, txIrq}, 0);
    chk("R13", "idle stage", stage, 0);
    setupStage(8'h00);
    pkt(1'b0, 8'h00);
    chk("R13", "orphan pkt hs", hsValid, 0);
    chk("R13", "orphan pkt rxIrq", rxIrq, 0);
    chk("R13", "orphan stage", stage, 2);
    tokIn();
    pkt(1'b1, 8'h00);
    chk("R13", "finish idle", stage, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWrite();
    testRead();
    testNoData();
    testStall();
    testStallInSetup();
    testRestart();
    testBadStatus();
    testFlags();
    testOrphans();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

endmodule